// File: doc/BRIEF.md
# Flash Command Sequencer with Status Polling

This block sits between a byte-wide microcontroller bus and a small sectored flash array that is modelled in registers. Bus writes are decoded as multi-cycle command sequences. Each sequence starts with two unlock writes of fixed address/data pairs. The command set covers byte program, sector erase, a return to plain reads, and a query of a sector's protection flag. Ordinary reads return array contents.

Program and erase run as timed embedded operations. A cycle counter stands in for cell timing, and `busy` is high for the whole operation. While an operation runs, reads that hit the target return a polling byte instead of array data. For a program, the target is the byte being programmed. For an erase, it is any byte of the sector being erased. In the polling byte, bit 7 carries the complement of the programmed bit 7 during a program, and 0 during an erase. The other bits of the polling byte are 0.

The protection flags are fixed per sector by a build-time parameter. A program into a protected sector is dropped. An erase of a protected sector runs a hold interval that changes nothing.

Top module: `flash_cmd_seq`

## Requirements
- R1: After reset `busy` and `bus_rvalid` are low, every array byte reads FFh, and ordinary reads return array contents.
- R2: The writes AAh@55h, 55h@2Ah, A0h@55h and then D@A program byte A to (old AND D); the new value is readable once the operation has ended.
- R3: While a program runs, a read of the programmed address returns {~D[7], 7'b0}; reads of other addresses return array contents.
- R4: The writes AAh@55h, 55h@2Ah, 80h@55h, AAh@55h, 55h@2Ah, 30h@A erase the sector holding A (address bits [5:4] with the default sizes) to all FFh. While the erase runs, reads inside that sector return 00h. Other sectors keep their contents.
- R5: A program whose target lies in a protected sector leaves `busy` low and the array unchanged. Sector 2 (bytes 20h–2Fh) is the protected sector by default.
- R6: An erase aimed at a protected sector holds `busy` for HOLD_CYC cycles. During that time, reads inside the sector return 00h. Afterwards the sector holds its old contents.
- R7: After AAh@55h, 55h@2Ah, 90h@55h, the block is in query mode. In query mode, a read with address bit 6 = 0, bit 1 = 1 and bit 0 = 0 returns 01h if exactly one `sector_sel` bit is set and that sector is protected, and 00h otherwise. Every other read in query mode returns array contents.
- R8: F0h written as the third write of a sequence returns the block to read mode. Any write made while in query mode also returns it to read mode. In both cases the array is not changed.
- R9: A write that breaks the expected unlock address/data pattern returns the decoder to read mode with the array unchanged.
- R10: Writes made while `busy` is high are ignored, even when they form a complete command.
- R11: `bus_rdata` is valid, with `bus_rvalid` high, exactly one cycle after a cycle with `bus_rd` high.
- R12: `busy` is high for exactly PROG_CYC cycles for a program and ERASE_CYC cycles for an erase. It rises one cycle after the last write of the command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe, one cycle per read |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 8 | Write data |
| sector_sel | input | NSEC | One-hot sector select for the protection query |
| bus_rdata | output | 8 | Read data, valid with bus_rvalid |
| bus_rvalid | output | 1 | Read data valid |
| busy | output | 1 | Embedded operation in progress |

## Verification
The bench polls during each operation at the exact target and at a neighbouring address. A design that compared only the sector bits for a program would return the polling byte at the neighbour. A design that inverted the wrong bit would return 80h where 00h is expected.

The bench programs a byte twice, which catches a design that overwrites instead of ANDing. It sends a full command while `busy` is high, which exposes a decoder that keeps decoding during an operation. It sends broken unlock sequences and an F0h third write, which exposes a decoder that resynchronises on a later write.

The query reads use a bit-6 mismatch, a bit-0 mismatch, and zero or several selected sectors. These catch a match on partial address bits and a non-one-hot select that reads as protected. The busy cycle counts are compared exactly against the three duration parameters.

// File: rtl/fcs_pkg.sv
package fcs_pkg;

  typedef enum logic [2:0] {
    D_READ,
    D_UNLK1,
    D_UNLK2,
    D_PROG,
    D_ERA1,
    D_ERA2,
    D_ERA3,
    D_QUERY
  } dec_state_t;

  typedef enum logic [1:0] {
    OP_NONE,
    OP_PROG,
    OP_ERASE,
    OP_HOLD
  } op_kind_t;

  localparam logic [7:0] KEY_FIRST  = 8'hAA;
  localparam logic [7:0] KEY_SECOND = 8'h55;
  localparam logic [7:0] CMD_PROG   = 8'hA0;
  localparam logic [7:0] CMD_ERASE  = 8'h80;
  localparam logic [7:0] CMD_QUERY  = 8'h90;
  localparam logic [7:0] CMD_SECTOR = 8'h30;
  localparam logic [7:0] ERASED     = 8'hFF;

endpackage

// File: rtl/fcs_rst_sync.sv
module fcs_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);

  logic stage1_q;
  logic stage2_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      stage1_q <= 1'b0;
      stage2_q <= 1'b0;
    end else begin
      stage1_q <= 1'b1;
      stage2_q <= stage1_q;
    end
  end

  assign srst_n = stage2_q;

endmodule

// File: rtl/fcs_decode.sv
module fcs_decode
  import fcs_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int NSEC      = 4,
  parameter int BYTE_BITS = 4,
  parameter int IDX_W     = 6,
  parameter logic [ADDR_W-1:0] UNLK_ADDR1 = 'h55,
  parameter logic [ADDR_W-1:0] UNLK_ADDR2 = 'h2A
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wdata,
  input  logic              busy,
  input  logic [NSEC-1:0]   prot_flags,
  output logic              start,
  output op_kind_t          start_kind,
  output logic [IDX_W-1:0]  start_addr,
  output logic [7:0]        start_data,
  output logic              in_query
);

  localparam int SEC_BITS = IDX_W - BYTE_BITS;

  dec_state_t          state_q, state_d;
  logic [SEC_BITS-1:0] wr_sector;
  logic                wr_protected;
  logic                at_unlk1;
  logic                at_unlk2;

  assign wr_sector    = addr[IDX_W-1:BYTE_BITS];
  assign wr_protected = prot_flags[wr_sector];
  assign at_unlk1     = (addr == UNLK_ADDR1);
  assign at_unlk2     = (addr == UNLK_ADDR2);

  always_comb begin
    state_d    = state_q;
    start      = 1'b0;
    start_kind = OP_NONE;
    if (wr && !busy) begin
      unique case (state_q)
        D_READ: begin
          if (at_unlk1 && wdata == KEY_FIRST) state_d = D_UNLK1;
        end
        D_UNLK1: begin
          state_d = (at_unlk2 && wdata == KEY_SECOND) ? D_UNLK2 : D_READ;
        end
        D_UNLK2: begin
          state_d = D_READ;
          if (at_unlk1) begin
            if (wdata == CMD_PROG)       state_d = D_PROG;
            else if (wdata == CMD_ERASE) state_d = D_ERA1;
            else if (wdata == CMD_QUERY) state_d = D_QUERY;
          end
        end
        D_PROG: begin
          state_d = D_READ;
          if (!wr_protected) begin
            start      = 1'b1;
            start_kind = OP_PROG;
          end
        end
        D_ERA1: begin
          state_d = (at_unlk1 && wdata == KEY_FIRST) ? D_ERA2 : D_READ;
        end
        D_ERA2: begin
          state_d = (at_unlk2 && wdata == KEY_SECOND) ? D_ERA3 : D_READ;
        end
        D_ERA3: begin
          state_d = D_READ;
          if (wdata == CMD_SECTOR) begin
            start      = 1'b1;
            start_kind = wr_protected ? OP_HOLD : OP_ERASE;
          end
        end
        D_QUERY: begin
          state_d = D_READ;
        end
        default: state_d = D_READ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= D_READ;
    else        state_q <= state_d;
  end

  assign start_addr = addr[IDX_W-1:0];
  assign start_data = wdata;
  assign in_query   = (state_q == D_QUERY);

endmodule

// File: rtl/fcs_timer.sv
module fcs_timer
  import fcs_pkg::*;
#(
  parameter int IDX_W     = 6,
  parameter int PROG_CYC  = 64,
  parameter int ERASE_CYC = 512,
  parameter int HOLD_CYC  = 256
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  op_kind_t         start_kind,
  input  logic [IDX_W-1:0] start_addr,
  input  logic [7:0]       start_data,
  output logic             busy,
  output logic             done,
  output op_kind_t         op_kind,
  output logic [IDX_W-1:0] op_addr,
  output logic [7:0]       op_data
);

  localparam int MAX_A = (PROG_CYC > ERASE_CYC) ? PROG_CYC : ERASE_CYC;
  localparam int MAX_C = (MAX_A > HOLD_CYC) ? MAX_A : HOLD_CYC;
  localparam int CNT_W = $clog2(MAX_C + 1);

  logic             busy_q, busy_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             load;
  op_kind_t         kind_q;
  logic [IDX_W-1:0] addr_q;
  logic [7:0]       data_q;

  always_comb begin
    busy_d = busy_q;
    cnt_d  = cnt_q;
    load   = 1'b0;
    done   = busy_q && (cnt_q == '0);
    if (busy_q) begin
      if (cnt_q == '0) busy_d = 1'b0;
      else             cnt_d  = cnt_q - 1'b1;
    end else if (start) begin
      busy_d = 1'b1;
      load   = 1'b1;
      unique case (start_kind)
        OP_PROG:  cnt_d = CNT_W'(PROG_CYC - 1);
        OP_ERASE: cnt_d = CNT_W'(ERASE_CYC - 1);
        default:  cnt_d = CNT_W'(HOLD_CYC - 1);
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      busy_q <= busy_d;
      cnt_q  <= cnt_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      kind_q <= OP_NONE;
      addr_q <= '0;
      data_q <= '0;
    end else if (load) begin
      kind_q <= start_kind;
      addr_q <= start_addr;
      data_q <= start_data;
    end
  end

  assign busy    = busy_q;
  assign op_kind = kind_q;
  assign op_addr = addr_q;
  assign op_data = data_q;

endmodule

// File: rtl/fcs_store.sv
module fcs_store
  import fcs_pkg::*;
#(
  parameter int NSEC      = 4,
  parameter int SEC_BYTES = 16,
  parameter int IDX_W     = 6,
  parameter int BYTE_BITS = 4,
  parameter logic [NSEC-1:0] PROT_INIT = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             commit,
  input  op_kind_t         commit_kind,
  input  logic [IDX_W-1:0] commit_addr,
  input  logic [7:0]       commit_data,
  input  logic [IDX_W-1:0] rd_addr,
  output logic [7:0]       rd_byte,
  output logic [NSEC-1:0]  prot_flags
);

  localparam int TOTAL    = NSEC * SEC_BYTES;
  localparam int SEC_BITS = IDX_W - BYTE_BITS;

  logic [7:0]       mem_q [TOTAL];
  logic [7:0]       nxt   [TOTAL];
  logic [TOTAL-1:0] we;

  logic do_prog;
  logic do_erase;
  assign do_prog  = commit && (commit_kind == OP_PROG);
  assign do_erase = commit && (commit_kind == OP_ERASE);

  for (genvar i = 0; i < TOTAL; i++) begin : g_byte
    logic hit_byte;
    logic hit_sec;
    assign hit_byte = (commit_addr == IDX_W'(i));
    assign hit_sec  = (commit_addr[IDX_W-1:BYTE_BITS] == SEC_BITS'(i / SEC_BYTES));
    assign we[i]    = (do_prog && hit_byte) || (do_erase && hit_sec);
    assign nxt[i]   = do_erase ? ERASED : (mem_q[i] & commit_data);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < TOTAL; i++) mem_q[i] <= ERASED;
    end else begin
      for (int i = 0; i < TOTAL; i++) begin
        if (we[i]) mem_q[i] <= nxt[i];
      end
    end
  end

  assign rd_byte    = mem_q[rd_addr];
  assign prot_flags = PROT_INIT;

endmodule

// File: rtl/flash_cmd_seq.sv
module flash_cmd_seq
  import fcs_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int NSEC      = 4,
  parameter int SEC_BYTES = 16,
  parameter int PROG_CYC  = 64,
  parameter int ERASE_CYC = 512,
  parameter int HOLD_CYC  = 256,
  parameter logic [NSEC-1:0]   PROT_INIT  = 4'b0100,
  parameter logic [ADDR_W-1:0] UNLK_ADDR1 = 'h55,
  parameter logic [ADDR_W-1:0] UNLK_ADDR2 = 'h2A
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [7:0]        bus_wdata,
  input  logic [NSEC-1:0]   sector_sel,
  output logic [7:0]        bus_rdata,
  output logic              bus_rvalid,
  output logic              busy
);

  localparam int BYTE_BITS = $clog2(SEC_BYTES);
  localparam int SEC_BITS  = $clog2(NSEC);
  localparam int IDX_W     = BYTE_BITS + SEC_BITS;

  logic             rst_q_n;
  logic             start;
  op_kind_t         start_kind;
  logic [IDX_W-1:0] start_addr;
  logic [7:0]       start_data;
  logic             in_query;
  logic             done;
  op_kind_t         op_kind;
  logic [IDX_W-1:0] op_addr;
  logic [7:0]       op_data;
  logic [NSEC-1:0]  prot_flags;
  logic [IDX_W-1:0] rd_idx;
  logic [7:0]       array_byte;

  fcs_rst_sync u_rst (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (rst_q_n)
  );

  fcs_decode #(
    .ADDR_W     (ADDR_W),
    .NSEC       (NSEC),
    .BYTE_BITS  (BYTE_BITS),
    .IDX_W      (IDX_W),
    .UNLK_ADDR1 (UNLK_ADDR1),
    .UNLK_ADDR2 (UNLK_ADDR2)
  ) u_dec (
    .clk        (clk),
    .rst_n      (rst_q_n),
    .wr         (bus_wr),
    .addr       (bus_addr),
    .wdata      (bus_wdata),
    .busy       (busy),
    .prot_flags (prot_flags),
    .start      (start),
    .start_kind (start_kind),
    .start_addr (start_addr),
    .start_data (start_data),
    .in_query   (in_query)
  );

  fcs_timer #(
    .IDX_W     (IDX_W),
    .PROG_CYC  (PROG_CYC),
    .ERASE_CYC (ERASE_CYC),
    .HOLD_CYC  (HOLD_CYC)
  ) u_tmr (
    .clk        (clk),
    .rst_n      (rst_q_n),
    .start      (start),
    .start_kind (start_kind),
    .start_addr (start_addr),
    .start_data (start_data),
    .busy       (busy),
    .done       (done),
    .op_kind    (op_kind),
    .op_addr    (op_addr),
    .op_data    (op_data)
  );

  assign rd_idx = bus_addr[IDX_W-1:0];

  fcs_store #(
    .NSEC      (NSEC),
    .SEC_BYTES (SEC_BYTES),
    .IDX_W     (IDX_W),
    .BYTE_BITS (BYTE_BITS),
    .PROT_INIT (PROT_INIT)
  ) u_mem (
    .clk         (clk),
    .rst_n       (rst_q_n),
    .commit      (done),
    .commit_kind (op_kind),
    .commit_addr (op_addr),
    .commit_data (op_data),
    .rd_addr     (rd_idx),
    .rd_byte     (array_byte),
    .prot_flags  (prot_flags)
  );

  // Read path: polling byte, protection query, or array contents
  logic       poll_hit;
  logic       query_hit;
  logic       sel_prot;
  logic [7:0] poll_byte;
  logic [7:0] rdata_d;
  logic [7:0] rdata_q;
  logic       rvalid_q;

  always_comb begin
    poll_hit = 1'b0;
    if (busy) begin
      if (op_kind == OP_PROG) poll_hit = (rd_idx == op_addr);
      else poll_hit = (rd_idx[IDX_W-1:BYTE_BITS] == op_addr[IDX_W-1:BYTE_BITS]);
    end
    poll_byte = (op_kind == OP_PROG) ? {~op_data[7], 7'b0} : 8'h00;
    query_hit = in_query && !bus_addr[6] && bus_addr[1] && !bus_addr[0];
    sel_prot  = $onehot(sector_sel) && |(sector_sel & prot_flags);
    if (poll_hit)       rdata_d = poll_byte;
    else if (query_hit) rdata_d = {7'b0, sel_prot};
    else                rdata_d = array_byte;
  end

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) rvalid_q <= 1'b0;
    else          rvalid_q <= bus_rd;
  end

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n)    rdata_q <= '0;
    else if (bus_rd) rdata_q <= rdata_d;
  end

  assign bus_rdata  = rdata_q;
  assign bus_rvalid = rvalid_q;

endmodule

// File: rtl/fcs_checker.sv
module fcs_checker
  import fcs_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int NSEC      = 4,
  parameter int IDX_W     = 6,
  parameter int BYTE_BITS = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_rd,
  input logic              bus_wr,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [7:0]        bus_rdata,
  input logic              bus_rvalid,
  input logic              busy,
  input op_kind_t          op_kind,
  input logic [IDX_W-1:0]  op_addr,
  input logic [NSEC-1:0]   prot_flags,
  input logic              in_query
);

  assert_rvalid_follows_R11: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rd |=> bus_rvalid);

  assert_rvalid_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd |=> !bus_rvalid);

  assert_busy_after_write_R12: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(bus_wr));

  assert_prog_poll_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && op_kind == OP_PROG && bus_rd && bus_addr[IDX_W-1:0] == op_addr)
      |=> (bus_rdata[6:0] == 7'd0));

  assert_erase_poll_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && op_kind != OP_PROG && bus_rd &&
     bus_addr[IDX_W-1:BYTE_BITS] == op_addr[IDX_W-1:BYTE_BITS])
      |=> (bus_rdata == 8'h00));

  assert_no_protected_prog_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> !(op_kind == OP_PROG && prot_flags[op_addr[IDX_W-1:BYTE_BITS]]));

  assert_query_byte_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (in_query && bus_rd && !bus_addr[6] && bus_addr[1] && !bus_addr[0])
      |=> (bus_rdata[7:1] == 7'd0));

  assert_op_frozen_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> ($stable(op_addr) && $stable(op_kind)));

endmodule

bind flash_cmd_seq fcs_checker #(
  .ADDR_W    (ADDR_W),
  .NSEC      (NSEC),
  .IDX_W     (IDX_W),
  .BYTE_BITS (BYTE_BITS)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_q_n),
  .bus_rd     (bus_rd),
  .bus_wr     (bus_wr),
  .bus_addr   (bus_addr),
  .bus_rdata  (bus_rdata),
  .bus_rvalid (bus_rvalid),
  .busy       (busy),
  .op_kind    (op_kind),
  .op_addr    (op_addr),
  .prot_flags (prot_flags),
  .in_query   (in_query)
);

// File: tb/sim_flash_cmd_seq.sv
module sim_flash_cmd_seq;

  localparam int CLK_PERIOD = 10;
  localparam int P_PROG  = 12;
  localparam int P_ERASE = 20;
  localparam int P_HOLD  = 16;

  logic       clk;
  logic       rst_n;
  logic       bus_wr;
  logic       bus_rd;
  logic [7:0] bus_addr;
  logic [7:0] bus_wdata;
  logic [3:0] sector_sel;
  logic [7:0] bus_rdata;
  logic       bus_rvalid;
  logic       busy;

  flash_cmd_seq #(
    .PROG_CYC  (P_PROG),
    .ERASE_CYC (P_ERASE),
    .HOLD_CYC  (P_HOLD)
  ) u0 (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_wr     (bus_wr),
    .bus_rd     (bus_rd),
    .bus_addr   (bus_addr),
    .bus_wdata  (bus_wdata),
    .sector_sel (sector_sel),
    .bus_rdata  (bus_rdata),
    .bus_rvalid (bus_rvalid),
    .busy       (busy)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  typedef struct {
    logic [7:0] exp;
    string      req;
    logic [7:0] addr;
  } exp_t;

  exp_t       sb_q[$];
  int         n_cmp = 0;
  int         n_bad = 0;
  bit         finished = 0;
  logic [7:0] model [64];

  task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string req,
                     input string what);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // Monitor: pops expected read data as results appear
  always @(negedge clk) begin
    if (bus_rvalid) begin
      exp_t e;
      if (sb_q.size() == 0) begin
        n_cmp++;
        n_bad++;
        $display("FAIL R11 unexpected read data: actual %h expected none", bus_rdata);
      end else begin
        e = sb_q.pop_front();
        chk(bus_rdata, e.exp, e.req, $sformatf("read @%h", e.addr));
      end
    end
  end

  task automatic do_wr(input logic [7:0] a, input logic [7:0] d);
    bus_addr  = a;
    bus_wdata = d;
    bus_wr    = 1'b1;
    @(negedge clk);
    bus_wr    = 1'b0;
  endtask

  task automatic do_rd(input logic [7:0] a, input logic [7:0] e, input string req);
    bus_addr = a;
    bus_rd   = 1'b1;
    sb_q.push_back('{e, req, a});
    @(negedge clk);
    bus_rd   = 1'b0;
  endtask

  task automatic prog(input logic [7:0] a, input logic [7:0] d);
    do_wr(8'h55, 8'hAA);
    do_wr(8'h2A, 8'h55);
    do_wr(8'h55, 8'hA0);
    do_wr(a, d);
  endtask

  task automatic erase(input logic [7:0] a);
    do_wr(8'h55, 8'hAA);
    do_wr(8'h2A, 8'h55);
    do_wr(8'h55, 8'h80);
    do_wr(8'h55, 8'hAA);
    do_wr(8'h2A, 8'h55);
    do_wr(a, 8'h30);
  endtask

  task automatic wait_idle(output int n);
    n = 0;
    while (busy) begin
      n++;
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual running expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    int n;
    for (int i = 0; i < 64; i++) model[i] = 8'hFF;
    bus_wr = 0; bus_rd = 0; bus_addr = 0; bus_wdata = 0; sector_sel = 0;
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);

    // R1: reset state
    chk({7'b0, busy}, 8'h00, "R1", "busy after reset");
    chk({7'b0, bus_rvalid}, 8'h00, "R1", "rvalid after reset");
    do_rd(8'h00, 8'hFF, "R1");
    do_rd(8'h3F, 8'hFF, "R1");

    // R2 / R3 / R12: first program with polling
    prog(8'h05, 8'h3C);
    chk({7'b0, busy}, 8'h01, "R12", "busy right after program");
    do_rd(8'h05, 8'h80, "R3");   // complement of bit 7 of 3Ch
    do_rd(8'h06, 8'hFF, "R3");   // neighbour returns array
    wait_idle(n);
    chk(8'(n + 2), 8'(P_PROG), "R12", "program busy cycles");
    model[5] = 8'h3C;
    do_rd(8'h05, 8'h3C, "R2");

    // R2: AND with old contents; R12 exact duration
    prog(8'h05, 8'hF0);
    wait_idle(n);
    chk(8'(n), 8'(P_PROG), "R12", "program busy cycles clean");
    model[5] = 8'h30;
    do_rd(8'h05, 8'h30, "R2");

    // R10: full command during busy is ignored
    prog(8'h10, 8'h81);
    prog(8'h11, 8'h00);
    wait_idle(n);
    model[16] = 8'h81;
    do_rd(8'h10, 8'h81, "R10");
    do_rd(8'h11, 8'hFF, "R10");

    // R4: sector erase with polling
    prog(8'h1C, 8'h12);
    wait_idle(n);
    erase(8'h13);
    do_rd(8'h1C, 8'h00, "R4");
    do_rd(8'h05, model[5], "R4");
    wait_idle(n);
    chk(8'(n + 2), 8'(P_ERASE), "R12", "erase busy cycles");
    do_rd(8'h10, 8'hFF, "R4");
    do_rd(8'h1C, 8'hFF, "R4");
    do_rd(8'h05, 8'h30, "R4");
    model[16] = 8'hFF;

    // R5: protected program is dropped
    prog(8'h22, 8'h00);
    chk({7'b0, busy}, 8'h00, "R5", "busy after protected program");
    do_rd(8'h22, 8'hFF, "R5");

    // R6: protected erase runs hold interval only
    erase(8'h27);
    wait_idle(n);
    chk(8'(n), 8'(P_HOLD), "R6", "hold busy cycles");
    erase(8'h27);
    do_rd(8'h25, 8'h00, "R6");
    wait_idle(n);
    do_rd(8'h25, 8'hFF, "R6");

    // R7: protection query
    prog(8'h02, 8'h5A);
    wait_idle(n);
    model[2] = 8'h5A;
    do_wr(8'h55, 8'hAA);
    do_wr(8'h2A, 8'h55);
    do_wr(8'h55, 8'h90);
    sector_sel = 4'b0100;
    do_rd(8'h02, 8'h01, "R7");
    sector_sel = 4'b0010;
    do_rd(8'h02, 8'h00, "R7");
    sector_sel = 4'b0100;
    do_rd(8'h42, 8'h5A, "R7");   // bit 6 set: array
    do_rd(8'h03, 8'hFF, "R7");   // bit 0 set: array
    sector_sel = 4'b0110;
    do_rd(8'h02, 8'h00, "R7");
    sector_sel = 4'b0000;
    do_rd(8'h02, 8'h00, "R7");

    // R8: any write leaves query mode
    do_wr(8'h00, 8'hF0);
    sector_sel = 4'b0100;
    do_rd(8'h02, 8'h5A, "R8");

    // R8: F0h as third write
    do_wr(8'h55, 8'hAA);
    do_wr(8'h2A, 8'h55);
    do_wr(8'h55, 8'hF0);
    do_wr(8'h33, 8'h00);
    chk({7'b0, busy}, 8'h00, "R8", "busy after reset command");
    do_rd(8'h33, 8'hFF, "R8");
    prog(8'h33, 8'h0F);
    wait_idle(n);
    do_rd(8'h33, 8'h0F, "R8");

    // R9: broken unlock patterns
    do_wr(8'h55, 8'hAA);
    do_wr(8'h2A, 8'h00);
    do_wr(8'h55, 8'hA0);
    do_wr(8'h30, 8'h3C);
    chk({7'b0, busy}, 8'h00, "R9", "busy after bad data");
    do_wr(8'h55, 8'hAA);
    do_wr(8'h2A, 8'h55);
    do_wr(8'h56, 8'hA0);
    do_wr(8'h31, 8'h00);
    chk({7'b0, busy}, 8'h00, "R9", "busy after bad address");
    do_rd(8'h30, 8'hFF, "R9");
    do_rd(8'h31, 8'hFF, "R9");

    // R11: no read data without a strobe
    @(negedge clk);
    chk({7'b0, bus_rvalid}, 8'h00, "R11", "rvalid idle");
    repeat (3) @(negedge clk);
    if (sb_q.size() != 0) begin
      n_cmp++;
      n_bad++;
      $display("FAIL R11 missing read data: actual %0d pending expected 0", sb_q.size());
    end

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule